// File: doc/BRIEF.md
# Wired Interrupt to Message Translator

This block watches a bank of 207 level-style interrupt wires from a peripheral subsystem and turns each new assertion into a message-signalled interrupt. It delivers every message as a single write on a valid/ready memory-write request port. No dedicated wire runs to the remote interrupt controller. Each wire has its own configuration entry with three fields: an enable bit, a 3-bit group code and an 8-bit event number. The group code does two jobs. It chooses which doorbell address the write goes to, and it travels in the write data beside the event number. Inputs can therefore land in different groups on the remote side.

Software programs the entries and the four doorbell addresses through a one-cycle command port. The same port offers a bulk command that switches off every entry of one group and leaves the entries of all other groups alone. Pending inputs are served in round-robin order, so that a busy low-numbered wire cannot starve the rest. A combinational read port returns any entry for inspection.

Top module: `irq_msi_bridge`

## Requirements
- R1: After reset `wr_valid` is 0 and every entry reads back as 0 on `rd_entry`.
- R2: A 0-to-1 change on an enabled input produces exactly one write. Holding the input high produces no further writes. `wr_data[10:8]` carries the group, `wr_data[7:0]` the event, and bits 31..11 are zero.
- R3: The write address is the doorbell of the entry's group. The command `cfg_op`=1 writes `cfg_wdata` into doorbell `cfg_idx[1:0]`. Group codes are 0 non-secure, 1 secure, 2 system error, 3 RAM error.
- R4: An input whose entry has enable 0, or has a group code of 4 to 7, never produces a write. The command `cfg_op`=0 writes `cfg_wdata[11:0]` into entry `cfg_idx` as {enable[11], group[10:8], event[7:0]}.
- R5: While `wr_valid` is 1 and `wr_ready` is 0, the request stays up with stable address and data. It drops after acceptance unless another input is pending.
- R6: After serving input i, the next write goes to the lowest-numbered pending input above i. When none is pending above i, the search wraps to input 0.
- R7: The command `cfg_op`=2 clears the enable bit of every entry whose group equals `cfg_wdata[2:0]`. It leaves the group and event fields untouched, and it leaves all entries of other groups unchanged.
- R8: A new rising edge on an input that arrives while that input's earlier write is still waiting for `wr_ready` produces a second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 207 | Wired interrupt inputs |
| cfg_we | input | 1 | Command strobe, one cycle per command |
| cfg_op | input | 2 | 0 entry write, 1 doorbell write, 2 clear group |
| cfg_idx | input | 8 | Entry index, or doorbell index in bits 1..0 |
| cfg_wdata | input | 32 | Command data |
| rd_idx | input | 8 | Entry index to inspect |
| rd_entry | output | 12 | {enable, group, event} of the inspected entry, 0 if out of range |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 32 | Doorbell address of the write |
| wr_data | output | 32 | Message payload |

## Verification
The hardest situation to reach is a set of simultaneous pending inputs that must come out in wrap-around order while the write port is stalled. The stimulus holds `wr_ready` low, raises several inputs above and below the last one served in the same cycle, and then releases the port. It also re-pulses an input whose message is still stalled, to check R8. A behavioural model that searches cyclically through plain arrays predicts every cycle's request, and the bench compares the order of the accepted payloads against a hand-derived list.

// File: rtl/irq_msi_pkg.sv
package irq_msi_pkg;
    localparam int NUM_IRQ  = 207;
    localparam int EVT_W    = 8;
    localparam int GRP_W    = 3;
    localparam int NUM_GRP  = 4;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = $clog2(NUM_IRQ);
    localparam int GSEL_W   = $clog2(NUM_GRP);
    localparam int ENTRY_W  = 1 + GRP_W + EVT_W;

    typedef struct packed {
        logic             en;
        logic [GRP_W-1:0] grp;
        logic [EVT_W-1:0] evt;
    } cfg_entry_t;

    typedef enum logic [1:0] {
        OP_ENTRY    = 2'd0,
        OP_DOORBELL = 2'd1,
        OP_CLEAR    = 2'd2,
        OP_NONE     = 2'd3
    } cfg_op_e;

    function automatic logic [DATA_W-1:0] mk_payload(cfg_entry_t e);
        logic [DATA_W-1:0] d;
        d = '0;
        d[GRP_W+EVT_W-1:0] = {e.grp, e.evt};
        return d;
    endfunction

    function automatic logic entry_live(cfg_entry_t e);
        return e.en && (int'(e.grp) < NUM_GRP);
    endfunction
endpackage

// File: rtl/irq_cfg_table.sv
module irq_cfg_table
    import irq_msi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_op,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [IDX_W-1:0]    sel_idx,
    output cfg_entry_t          sel_entry,
    output logic [ADDR_W-1:0]   sel_addr,
    input  logic [IDX_W-1:0]    rd_idx,
    output cfg_entry_t          rd_entry,
    output logic [NUM_IRQ-1:0]  live
);
    cfg_entry_t          tbl [NUM_IRQ];
    logic [ADDR_W-1:0]   db  [NUM_GRP];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_IRQ; i++) tbl[i] <= '0;
            for (int g = 0; g < NUM_GRP; g++) db[g] <= '0;
        end else if (cfg_we) begin
            case (cfg_op_e'(cfg_op))
                OP_ENTRY: begin
                    if (int'(cfg_idx) < NUM_IRQ)
                        tbl[cfg_idx] <= cfg_entry_t'(cfg_wdata[ENTRY_W-1:0]);
                end
                OP_DOORBELL: db[cfg_idx[GSEL_W-1:0]] <= cfg_wdata[ADDR_W-1:0];
                OP_CLEAR: begin
                    for (int i = 0; i < NUM_IRQ; i++)
                        if (tbl[i].grp == cfg_wdata[GRP_W-1:0]) tbl[i].en <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_live
            assign live[i] = entry_live(tbl[i]);
        end
    endgenerate

    always_comb begin
        sel_entry = (int'(sel_idx) < NUM_IRQ) ? tbl[sel_idx] : '0;
        rd_entry  = (int'(rd_idx)  < NUM_IRQ) ? tbl[rd_idx]  : '0;
        sel_addr  = db[sel_entry.grp[GSEL_W-1:0]];
    end
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track
    import irq_msi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IRQ-1:0]  irq_in,
    input  logic [NUM_IRQ-1:0]  live,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    output logic [NUM_IRQ-1:0]  pend
);
    logic [NUM_IRQ-1:0] prev;
    logic [NUM_IRQ-1:0] rise;
    logic [NUM_IRQ-1:0] clr_mask;

    always_comb begin
        rise     = irq_in & ~prev;
        clr_mask = '0;
        if (clr_en) clr_mask[clr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            pend <= '0;
        end else begin
            prev <= irq_in;
            pend <= (pend | rise) & live & ~clr_mask;
        end
    end

    // R2: a fresh edge on a live input that is not being served is captured
    p_edge_captured_r2: assert property (@(posedge clk) disable iff (rst)
        ((rise & live & ~clr_mask) != '0) |=>
        ((pend & $past(rise & live & ~clr_mask)) == $past(rise & live & ~clr_mask)));
endmodule

// File: rtl/irq_rr_arb.sv
module irq_rr_arb
    import irq_msi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IRQ-1:0]  req,
    input  logic                advance,
    output logic                found,
    output logic [IDX_W-1:0]    idx
);
    logic [IDX_W-1:0] last;
    logic             hi_found;
    logic [IDX_W-1:0] hi_idx;
    logic             lo_found;
    logic [IDX_W-1:0] lo_idx;

    always_comb begin
        hi_found = 1'b0;
        hi_idx   = '0;
        lo_found = 1'b0;
        lo_idx   = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (req[i] && !lo_found) begin
                lo_found = 1'b1;
                lo_idx   = IDX_W'(i);
            end
            if (req[i] && (i > int'(last)) && !hi_found) begin
                hi_found = 1'b1;
                hi_idx   = IDX_W'(i);
            end
        end
        found = hi_found | lo_found;
        idx   = hi_found ? hi_idx : lo_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) last <= IDX_W'(NUM_IRQ - 1);
        else if (advance && found) last <= idx;
    end

    // R6: the arbiter only ever names an input that is requesting
    p_grant_in_req_r6: assert property (@(posedge clk) disable iff (rst)
        found |-> req[idx]);
endmodule

// File: rtl/irq_msi_bridge.sv
module irq_msi_bridge
    import irq_msi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IRQ-1:0]  irq_in,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_op,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [ENTRY_W-1:0]  rd_entry,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data
);
    logic [NUM_IRQ-1:0] live;
    logic [NUM_IRQ-1:0] pend;
    logic [NUM_IRQ-1:0] req;
    logic               found;
    logic [IDX_W-1:0]   pick;
    logic               load;
    cfg_entry_t         sel_entry;
    cfg_entry_t         rd_e;
    logic [ADDR_W-1:0]  sel_addr;

    assign req      = pend & live;
    assign load     = found && (!wr_valid || wr_ready);
    assign rd_entry = rd_e;

    irq_cfg_table u_cfg (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .sel_idx(pick), .sel_entry(sel_entry), .sel_addr(sel_addr),
        .rd_idx(rd_idx), .rd_entry(rd_e), .live(live)
    );

    irq_pend_track u_pend (
        .clk(clk), .rst(rst), .irq_in(irq_in), .live(live),
        .clr_en(load), .clr_idx(pick), .pend(pend)
    );

    irq_rr_arb u_arb (
        .clk(clk), .rst(rst), .req(req), .advance(load),
        .found(found), .idx(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (load) begin
            wr_valid <= 1'b1;
            wr_addr  <= sel_addr;
            wr_data  <= mk_payload(sel_entry);
        end else if (wr_ready) begin
            wr_valid <= 1'b0;
        end
    end

    // R5: a stalled request keeps its contents
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R5: the request only goes away after it was accepted
    p_drop_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_valid) |-> $past(wr_ready));
endmodule

// File: tb/test_irq_msi_bridge.sv
module test_irq_msi_bridge;
    localparam int N = 207;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_op = 2'd3;
    logic [7:0]    cfg_idx = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [7:0]    rd_idx = '0;
    logic [11:0]   rd_entry;
    logic          wr_valid;
    logic          wr_ready = 1'b1;
    logic [31:0]   wr_addr;
    logic [31:0]   wr_data;

    irq_msi_bridge i_irq_msi_bridge (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .rd_idx(rd_idx), .rd_entry(rd_entry),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cyc    = 0;

    // behavioural reference state
    bit          m_en   [N];
    int          m_grp  [N];
    int          m_evt  [N];
    bit          m_pend [N];
    bit          m_prev [N];
    logic [31:0] m_db   [4];
    bit          m_valid;
    logic [31:0] m_addr, m_data;
    int          m_last;

    logic [10:0] got_data [$];
    logic [31:0] got_addr [$];

    function automatic bit okv(int i);
        return m_en[i] && (m_grp[i] < 4);
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_en[i] = 0; m_grp[i] = 0; m_evt[i] = 0; m_pend[i] = 0; m_prev[i] = 0;
            end
            for (int g = 0; g < 4; g++) m_db[g] = '0;
            m_valid = 0; m_addr = '0; m_data = '0; m_last = N - 1;
        end else begin
            bit acc, room;
            int sel;
            acc  = m_valid && wr_ready;
            room = !m_valid || wr_ready;
            sel  = -1;
            for (int k = 1; k <= N; k++) begin
                int j;
                j = (m_last + k) % N;
                if (sel < 0 && m_pend[j] && okv(j)) sel = j;
            end
            for (int i = 0; i < N; i++) begin
                if (irq_in[i] && !m_prev[i]) m_pend[i] = 1;
                if (!okv(i)) m_pend[i] = 0;
                m_prev[i] = irq_in[i];
            end
            if (room && sel >= 0) begin
                m_valid = 1;
                m_addr  = m_db[m_grp[sel]];
                m_data  = (m_grp[sel] << 8) | m_evt[sel];
                m_last  = sel;
                m_pend[sel] = 0;
            end else if (acc) begin
                m_valid = 0;
            end
            if (cfg_we) begin
                if (cfg_op == 2'd0 && cfg_idx < N) begin
                    m_en[cfg_idx]  = cfg_wdata[11];
                    m_grp[cfg_idx] = int'(cfg_wdata[10:8]);
                    m_evt[cfg_idx] = int'(cfg_wdata[7:0]);
                end else if (cfg_op == 2'd1) begin
                    m_db[cfg_idx[1:0]] = cfg_wdata;
                end else if (cfg_op == 2'd2) begin
                    for (int i = 0; i < N; i++)
                        if (m_grp[i] == int'(cfg_wdata[2:0])) m_en[i] = 0;
                end
            end
            if (wr_valid && wr_ready) begin
                got_data.push_back(wr_data[10:0]);
                got_addr.push_back(wr_addr);
            end
        end
    end

    // every-cycle comparison against the model (R2, R3, R5)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(wr_valid == m_valid, "R5 wr_valid", 64'(wr_valid), 64'(m_valid));
            if (m_valid) begin
                chk(wr_addr == m_addr, "R3 wr_addr", 64'(wr_addr), 64'(m_addr));
                chk(wr_data == m_data, "R2 wr_data", 64'(wr_data), 64'(m_data));
            end
        end
    end

    task automatic summary();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            summary();
        end
    end

    task automatic cmd(logic [1:0] op, logic [7:0] idx, logic [31:0] d);
        cfg_we = 1; cfg_op = op; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0; cfg_op = 2'd3;
    endtask

    task automatic pulse(int i);
        irq_in[i] = 1'b1;
        @(negedge clk);
        irq_in[i] = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_chk(int i, logic [11:0] exp, string tag);
        rd_idx = 8'(i);
        #1;
        chk(rd_entry == exp, tag, 64'(rd_entry), 64'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(wr_valid == 1'b0, "R1 wr_valid after reset", 64'(wr_valid), 0);
        rd_chk(0,   12'h000, "R1 entry 0");
        rd_chk(206, 12'h000, "R1 entry 206");

        for (int g = 0; g < 4; g++) cmd(2'd1, 8'(g), 32'h1000_0040 + g * 32'h100);
        cmd(2'd0, 8'd5,   32'h815);
        cmd(2'd0, 8'd100, 32'hA64);
        cmd(2'd0, 8'd206, 32'hBCE);
        cmd(2'd0, 8'd7,   32'h107);
        cmd(2'd0, 8'd9,   32'hD09);
        rd_chk(100, 12'hA64, "R4 entry write readback");

        // R2: single write for a held-high level
        got_data.delete(); got_addr.delete();
        irq_in[5] = 1'b1;
        repeat (10) @(negedge clk);
        irq_in[5] = 1'b0;
        repeat (3) @(negedge clk);
        chk(got_data.size() == 1, "R2 one write per edge", 64'(got_data.size()), 1);
        if (got_data.size() == 1) begin
            chk(got_data[0] == 11'h015, "R2 payload", 64'(got_data[0]), 64'h015);
            chk(got_addr[0] == 32'h1000_0040, "R3 group 0 doorbell", 64'(got_addr[0]), 64'h1000_0040);
        end

        // R4: disabled entry and out-of-range group
        got_data.delete(); got_addr.delete();
        pulse(7);
        pulse(9);
        repeat (5) @(negedge clk);
        chk(got_data.size() == 0, "R4 no write from disabled/bad group", 64'(got_data.size()), 0);

        // R6: wrap-around order while stalled
        got_data.delete(); got_addr.delete();
        wr_ready = 1'b0;
        irq_in[100] = 1'b1; irq_in[206] = 1'b1; irq_in[5] = 1'b1;
        repeat (6) @(negedge clk);
        chk(wr_valid == 1'b1, "R5 held while stalled", 64'(wr_valid), 1);
        wr_ready = 1'b1;
        repeat (6) @(negedge clk);
        irq_in = '0;
        chk(got_data.size() == 3, "R6 three writes", 64'(got_data.size()), 3);
        if (got_data.size() == 3) begin
            chk(got_data[0] == 11'h264, "R6 first is 100", 64'(got_data[0]), 64'h264);
            chk(got_data[1] == 11'h3CE, "R6 second is 206", 64'(got_data[1]), 64'h3CE);
            chk(got_data[2] == 11'h015, "R6 wrap to 5", 64'(got_data[2]), 64'h015);
            chk(got_addr[0] == 32'h1000_0240, "R3 group 2 doorbell", 64'(got_addr[0]), 64'h1000_0240);
            chk(got_addr[1] == 32'h1000_0340, "R3 group 3 doorbell", 64'(got_addr[1]), 64'h1000_0340);
        end
        repeat (3) @(negedge clk);

        // R8: re-edge while own write is stalled
        got_data.delete(); got_addr.delete();
        wr_ready = 1'b0;
        pulse(5);
        repeat (3) @(negedge clk);
        pulse(5);
        repeat (3) @(negedge clk);
        wr_ready = 1'b1;
        repeat (6) @(negedge clk);
        chk(got_data.size() == 2, "R8 second write after re-edge", 64'(got_data.size()), 2);

        // R7: clear group 0 only
        cmd(2'd2, 8'd0, 32'd0);
        rd_chk(5,   12'h015, "R7 group 0 entry disabled, fields kept");
        rd_chk(7,   12'h107, "R7 group 1 entry untouched");
        rd_chk(100, 12'hA64, "R7 group 2 entry untouched");
        rd_chk(206, 12'hBCE, "R7 group 3 entry untouched");
        got_data.delete(); got_addr.delete();
        pulse(5);
        pulse(100);
        repeat (5) @(negedge clk);
        chk(got_data.size() == 1, "R7 only group 2 input writes", 64'(got_data.size()), 1);
        if (got_data.size() == 1)
            chk(got_data[0] == 11'h264, "R7 surviving payload", 64'(got_data[0]), 64'h264);

        summary();
    end
endmodule